// File: doc/BRIEF.md
# Raster-Scan 3x3 Fixed-Width Image Filter

The block applies a 3x3 two-dimensional FIR kernel to an image that arrives one pixel per clock in row-major order, 512 pixels per row. Pixels, coefficients, partial sums and the result are all 4-bit unsigned fractions. Each of the nine kernel taps has its own fixed-width multiplier. The multiplier keeps only the upper half of the 8-bit product, after a rounding bias has been added. The nine truncated terms are summed in 4-bit adders, and the sum is doubled by a one-bit left shift to restore the binary point for the next stage. The doubled value is registered.

Two line buffers supply the pixels of the previous two rows. Within each row, two short delay registers supply the left-hand neighbours. A free-running column counter pulses on the last column of every row. Only the in-row delay registers are cleared by the OR of that pulse and the block reset. Because of this, pixels at the right edge of one row never appear as left neighbours at the start of the next row. The line buffers are cleared only by the block reset.

The coefficients are static. They may change only while reset is held. Callers keep the sum of the coefficient magnitudes below one and present normalized pixels. The adders wrap modulo 16 when that rule is broken.

Top module: `fir2d_raster3x3`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output becomes 0 and all row history and in-row history is cleared. After release, rows and columns that precede the first pixel contribute zero.
- R2: Each tap term equals floor((c*x + 8) / 16). Here c and x are the 4-bit unsigned coefficient and pixel codes, so the result is never larger than c or x.
- R3: The nine tap terms are added modulo 16.
- R4: The output equals (2 * sum) mod 16, so output bit 0 is always 0.
- R5: The result for the pixel presented before clock edge k is on `pix_o` after edge k and holds until edge k+1.
- R6: Coefficient k = 3*i + j sits at `coef_i[4k+3:4k]`. It weights the pixel i rows above and j columns left of the current pixel (i, j in 0..2). A tap whose column lies left of column 0 contributes zero.
- R7: The taps with i = 1 and i = 2 use the pixels presented exactly 512 and 1024 clocks earlier.
- R8: The first pixel after reset release is column 0. The column count advances by one per clock and wraps from 511 to 0, with the row-end pulse on column 511.
- R9: The row-end clear touches only the in-row delays. The line buffers still carry the last pixel of each row, so at column 511 the taps above see the pixels of column 511 of earlier rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_i | input | 36 | Nine 4-bit kernel coefficients, tap k in bits 4k+3..4k |
| pix_i | input | 4 | Current pixel, one per clock, row-major |
| pix_o | output | 4 | Filtered, rescaled pixel, one clock after its input |

## Verification
Every result is due one clock edge after the pixel it belongs to is presented. The one output register is the only stage between the pixel input and `pix_o`. The stimulus drives each pixel on the falling edge and samples `pix_o` shortly after the next rising edge. At that point the output is compared with a value computed from the stored image. The reference uses the above-row contents delayed by exactly 512 and 1024 pixels. Column 0 and column 1 of each row are checked against a model that drops the taps left of column 0. This exposes any leak across a row boundary within the same sampling window.

// File: rtl/fir2d_pkg.sv
// Package: shared widths and types for the raster 3x3 filter.
// Assumes every datapath word (pixel, coefficient, tap term, sum) is the
// same unsigned fraction width.
package fir2d_pkg;
    localparam int unsigned SAMP_W = 4;
    localparam int unsigned KSIZE  = 3;
    typedef logic [SAMP_W-1:0] samp_t;
endpackage

// File: rtl/fir2d_fxmul.sv
// Module: fir2d_fxmul
// Fixed-width multiplier. Forms the full 2W-bit product of two W-bit
// unsigned fractions, adds a bias of half an output LSB, and keeps only
// the upper W bits. Assumes the biased product fits in 2W bits, which
// holds for any W because (2^W-1)^2 + 2^(W-1) < 2^(2W).
module fir2d_fxmul #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] coef_i,
    input  logic [W-1:0] samp_i,
    output logic [W-1:0] prod_o
);
    localparam int unsigned PW = 2 * W;
    localparam logic [PW-1:0] BIAS = PW'(1) << (W - 1);

    logic [PW-1:0] full_w;

    // Biased full-precision product, truncated to its upper half.
    always_comb begin
        full_w = (PW'(coef_i) * PW'(samp_i)) + BIAS;
        prod_o = full_w[PW-1:W];
    end

    // R2: the truncated term never exceeds either operand.
    always_comb begin
        assert_prod_bound_R2: assert (prod_o <= coef_i && prod_o <= samp_i);
    end
endmodule

// File: rtl/fir2d_colctr.sv
// Module: fir2d_colctr
// Column counter for a raster stream. Counts 0..IMG_W-1, one step per
// clock, and flags the last column of each row. Assumes one pixel
// arrives on every clock after reset release.
module fir2d_colctr #(
    parameter int unsigned IMG_W = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic row_end_o
);
    localparam int unsigned CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(IMG_W - 1);

    logic [CW-1:0] col_q;

    // Advance the column, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)             col_q <= '0;
        else if (col_q == LAST) col_q <= '0;
        else                    col_q <= col_q + CW'(1);
    end

    // Row-end pulse while the last column is being presented.
    always_comb row_end_o = (col_q == LAST);

    // R8: wrap from the last column back to column 0.
    assert_col_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q == LAST) |=> (col_q == '0));

    // R8: step by exactly one inside a row.
    assert_col_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q != LAST) |=> (col_q == $past(col_q) + CW'(1)));
endmodule

// File: rtl/fir2d_linebuf.sv
// Module: fir2d_linebuf
// Full-row delay: one head register followed by a DEPTH-1 stage shift
// register, so the output is the input from DEPTH clocks ago. Cleared
// only by the block reset. Assumes DEPTH >= 3.
module fir2d_linebuf #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] samp_i,
    output logic [W-1:0] samp_o
);
    localparam int unsigned SRW = (DEPTH - 1) * W;

    logic [W-1:0]   head_q;
    logic [SRW-1:0] sr_q;

    // Head register completes the row delay ahead of the shift chain.
    always_ff @(posedge clk) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= samp_i;
    end

    // Shift chain of DEPTH-1 words, newest at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[SRW-W-1:0], head_q};
    end

    // Oldest word leaves the buffer.
    always_comb samp_o = sr_q[SRW-1 -: W];
endmodule

// File: rtl/fir2d_tap_row.sv
// Module: fir2d_tap_row
// In-row tap line for one kernel row: the current sample plus KSIZE-1
// left neighbours. The neighbour registers clear on the OR of the block
// reset and the row-end pulse, so a new row starts with zero history.
module fir2d_tap_row #(
    parameter int unsigned W     = 4,
    parameter int unsigned KSIZE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               row_end_i,
    input  logic [W-1:0]       samp_i,
    output logic [KSIZE*W-1:0] taps_o
);
    localparam int unsigned DW = (KSIZE - 1) * W;

    logic          clr_w;
    logic [DW-1:0] d_q;

    // Row-boundary clear: block reset OR row-end pulse.
    always_comb clr_w = !rst_n || row_end_i;

    // Shift the left-neighbour registers, newest at slot 0.
    always_ff @(posedge clk) begin
        if (clr_w) begin
            d_q <= '0;
        end else begin
            d_q[0 +: W] <= samp_i;
            for (int k = 1; k < int'(KSIZE) - 1; k++) begin
                d_q[k*W +: W] <= d_q[(k-1)*W +: W];
            end
        end
    end

    // Tap j is the pixel j columns to the left.
    always_comb taps_o = {d_q, samp_i};

    // R6: after a row end, no neighbour from the finished row remains.
    assert_row_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_end_i |=> (d_q == '0));
endmodule

// File: rtl/fir2d_raster3x3.sv
// Module: fir2d_raster3x3
// Raster-scan 3x3 FIR filter with fixed-width arithmetic. Kernel row i
// is fed by the stream delayed by i full rows, and each row has its own
// in-row tap line. The nine fixed-width terms are summed modulo 2^W and
// doubled into the output register. Assumes static coefficients,
// normalized pixels and one pixel per clock from reset release.
module fir2d_raster3x3
    import fir2d_pkg::*;
#(
    parameter int unsigned IMG_W = 512
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [KSIZE*KSIZE*SAMP_W-1:0]   coef_i,
    input  logic [SAMP_W-1:0]               pix_i,
    output logic [SAMP_W-1:0]               pix_o
);
    localparam int unsigned W     = SAMP_W;
    localparam int unsigned NTAPS = KSIZE * KSIZE;

    logic                row_end_w;
    samp_t               row_in_w [KSIZE];
    logic [KSIZE*W-1:0]  taps_w   [KSIZE];
    samp_t               prod_w   [NTAPS];
    samp_t               sum_w;
    samp_t               out_q;

    fir2d_colctr #(.IMG_W(IMG_W)) colctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_end_o (row_end_w)
    );

    // Stream for kernel row 0 is the live input.
    always_comb row_in_w[0] = pix_i;

    for (genvar g = 0; g < int'(KSIZE); g++) begin : g_row
        if (g > 0) begin : g_lb
            fir2d_linebuf #(.W(W), .DEPTH(IMG_W)) linebuf_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .samp_i (row_in_w[g-1]),
                .samp_o (row_in_w[g])
            );
        end

        fir2d_tap_row #(.W(W), .KSIZE(KSIZE)) taprow_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .row_end_i (row_end_w),
            .samp_i    (row_in_w[g]),
            .taps_o    (taps_w[g])
        );

        for (genvar j = 0; j < int'(KSIZE); j++) begin : g_col
            fir2d_fxmul #(.W(W)) mul_i (
                .coef_i (coef_i[(g*KSIZE+j)*W +: W]),
                .samp_i (taps_w[g][j*W +: W]),
                .prod_o (prod_w[g*KSIZE+j])
            );
        end
    end

    // Modulo-2^W accumulation of all tap terms.
    always_comb begin
        sum_w = '0;
        for (int k = 0; k < int'(NTAPS); k++) begin
            sum_w = sum_w + prod_w[k];
        end
    end

    // Output register with the one-bit rescaling shift.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= {sum_w[W-2:0], 1'b0};
    end

    always_comb pix_o = out_q;

    // R1: the cycle after a reset edge shows a zero output.
    assert_reset_out_R1: assert property (@(posedge clk)
        !rst_n |=> (pix_o == '0));
endmodule

// File: tb/fir2d_raster3x3_tb_top.sv
`timescale 1ns/1ps
module fir2d_raster3x3_tb_top;
    localparam int W_IMG = 512;
    localparam int MAXR  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] coef = '0;
    logic [3:0]  pix = '0;
    logic [3:0]  pix_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int img [MAXR][W_IMG];
    int h   [9];

    always #2 clk = ~clk;

    fir2d_raster3x3 #(.IMG_W(W_IMG)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .coef_i (coef),
        .pix_i  (pix),
        .pix_o  (pix_o)
    );

    // R2: fixed-width term model.
    function automatic int fxmul(int c, int x);
        return ((c * x) + 8) >> 4;
    endfunction

    // R3 R4 R6 R7: expected output for pixel (r, c).
    function automatic int expect_out(int r, int c);
        int s = 0;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                if (r - i >= 0 && c - j >= 0)
                    s += fxmul(h[i*3+j], img[r-i][c-j]);
        return ((s % 16) * 2) % 16;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic load_coefs(int mode);
        for (int k = 0; k < 9; k++) begin
            case (mode)
                0: h[k] = $urandom_range(0, 3);
                1: h[k] = 15;
                default: h[k] = (k == 0) ? 15 : 0;
            endcase
            coef[k*4 +: 4] = 4'(h[k]);
        end
    endtask

    // Hold reset, confirm zero output (R1), then release at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pix = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(pix_o), 0);
        rst_n = 1'b1;
    endtask

    // Stream npix pixels; each result is sampled 1 ns after its edge (R5).
    task automatic stream(int npix, int pmode);
        for (int n = 0; n < npix; n++) begin
            int r = n / W_IMG;
            int c = n % W_IMG;
            int v;
            case ((pmode + r) % 3)
                0: v = $urandom_range(0, 15);
                1: v = c % 16;
                default: v = (c < 2 || c > W_IMG - 3) ? 15 : $urandom_range(0, 15);
            endcase
            img[r][c] = v;
            pix = 4'(v);
            @(posedge clk);
            #1;
            if (r == 0 && n < 3)
                check("R8 R1 first pixels after release", int'(pix_o), expect_out(r, c));
            else if (c < 2)
                check("R6 R8 row start, left taps cleared", int'(pix_o), expect_out(r, c));
            else if (c == W_IMG - 1 && r > 0)
                check("R9 R7 last column above taps", int'(pix_o), expect_out(r, c));
            else if (r < 2)
                check("R7 rows above start empty", int'(pix_o), expect_out(r, c));
            else
                check("R2 R3 R4 R5 interior", int'(pix_o), expect_out(r, c));
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        load_coefs(0);
        do_reset();
        stream(MAXR * W_IMG, 0);
        // Wrap-around corner: all coefficients at full scale.
        load_coefs(1);
        do_reset();
        stream(3 * W_IMG + 100, 1);
        // Mid-row reset followed by a single-tap kernel (R1 history cleared).
        load_coefs(2);
        do_reset();
        stream(3 * W_IMG, 2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule